// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Infrared Pulse Encoding

This block turns parallel bytes into asynchronous serial frames. A byte enters through a valid/ready holding port. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then one or two high stop bits. The frame engine does not count clock cycles. It advances on a 16x oversampling tick that an external baud generator supplies, so one bit period equals sixteen ticks.

Two line encodings are available:
- **Plain NRZ.** The line rests high. Each bit drives its own level for the whole bit period.
- **Infrared.** The line rests low. A zero bit, the start bit included, is sent as a high pulse that fills the first three of the sixteen ticks of that bit. A one bit leaves the line low.

The word length, the stop-bit count and the encoding are captured when a byte is accepted. They then stay fixed until the frame ends. If the encoding input is toggled during a frame, the output for that frame is not defined. A `busy` flag covers the whole frame.

Back-pressure rules:
- `in_ready` is high only while the transmitter is idle.
- A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- While a frame is in flight, `in_valid` and `in_data` are ignored. A holder that keeps `in_valid` asserted has its byte taken on the first edge after the frame ends.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in flight, `busy` is 0 and `in_ready` is 1. The line follows the live encoding input: high when `ir_mode` is 0, low when `ir_mode` is 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. While `busy` is 1, `in_ready` is 0. Any `in_valid`/`in_data` activity in that time leaves the frame in flight unchanged.
- R3: In NRZ mode a frame is a start bit at 0, then the data bits from bit 0 upward, then stop bits at 1. Each bit lasts exactly 16 `tick16` pulses.
- R4: `word_len` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R6: For word lengths below 8, the unused upper bits of `in_data` have no effect on the line.
- R7: In infrared mode, every zero bit (start bit included) is sent as 1 during its first 3 tick periods and 0 for the remaining 13. Every one bit and every stop bit is sent as 0.
- R8: `busy` rises on the cycle after acceptance. It stays 1 until the tick that ends the last stop bit, and falls on the next cycle.
- R9: `word_len`, `two_stop` and `ir_mode` are sampled at acceptance. Changing `word_len` or `two_stop` during a frame does not alter that frame.
- R10: Bit timing counts `tick16` pulses, not clock cycles. With a tick every third clock, each bit lasts 48 clocks, and the line holds still on clocks without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | 16x oversampling baud tick, one clock wide |
| in_valid | input | 1 | Byte offered on the holding port |
| in_ready | output | 1 | Transmitter can accept a byte |
| in_data | input | 8 | Byte to send; bit 0 goes first |
| word_len | input | 2 | Data bits per frame: 00=5, 01=6, 10=7, 11=8 |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| ir_mode | input | 1 | 0: NRZ line, 1: infrared pulse encoding |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in flight |

## Verification
The bench builds the block with its default parameters: 8-bit data, 16 ticks per bit, and a 3-tick pulse. These values match the field encodings and the 3/16 pulse shape in the requirements. The tick is driven from the bench, and its spacing can be changed per test. A run with a tick on every clock covers every sub-bit position at full speed. A run with a tick every third clock shows that the line holds between ticks. Frames are sent with every word length, both stop counts and both encodings. Some frames carry a disturbing mid-frame `in_valid` or format change, which brings the back-pressure and sample-at-start rules within reach.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       ir;
  } tx_fmt_t;

endpackage

// File: rtl/ser_tx_bitseq.sv
module ser_tx_bitseq
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  tx_fmt_t           fmt_in,
  output logic              busy,
  output logic              bit_level,
  output logic [$clog2(OVS)-1:0] sub_idx,
  output tx_fmt_t           fmt_q
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int MIN_W = DATA_W - 3;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  tx_phase_e         phase;
  logic [DATA_W-1:0] shreg;
  logic [SUB_W-1:0]  sub_cnt;
  logic [BIT_W-1:0]  left_cnt;
  logic              bit_end;

  assign bit_end = tick && (sub_cnt == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= TX_IDLE;
      shreg    <= '0;
      sub_cnt  <= '0;
      left_cnt <= '0;
      fmt_q    <= '0;
    end else if (phase == TX_IDLE) begin
      if (load) begin
        phase   <= TX_START;
        shreg   <= data;
        fmt_q   <= fmt_in;
        sub_cnt <= '0;
      end
    end else if (bit_end) begin
      sub_cnt <= '0;
      unique case (phase)
        TX_START: begin
          phase    <= TX_DATA;
          left_cnt <= BIT_W'(MIN_W - 1) + BIT_W'(fmt_q.wlen);
        end
        TX_DATA: begin
          shreg <= shreg >> 1;
          if (left_cnt == '0) begin
            phase    <= TX_STOP;
            left_cnt <= BIT_W'(fmt_q.stop2);
          end else begin
            left_cnt <= left_cnt - 1'b1;
          end
        end
        TX_STOP: begin
          if (left_cnt == '0) phase <= TX_IDLE;
          else                left_cnt <= left_cnt - 1'b1;
        end
        default: phase <= TX_IDLE;
      endcase
    end else if (tick) begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (phase)
      TX_START: bit_level = 1'b0;
      TX_DATA:  bit_level = shreg[0];
      default:  bit_level = 1'b1;
    endcase
  end

  assign busy    = (phase != TX_IDLE);
  assign sub_idx = sub_cnt;

endmodule

// File: rtl/ser_tx_shaper.sv
module ser_tx_shaper #(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic                   ir_sel,
  input  logic                   level,
  input  logic [$clog2(OVS)-1:0] sub_idx,
  output logic                   line
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] PULSE_END = SUB_W'(PULSE_TICKS);

  logic pulse_win;
  assign pulse_win = (sub_idx < PULSE_END);

  always_comb begin
    if (ir_sel) line = !level && pulse_win;
    else        line = level;
  end

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        word_len,
  input  logic              two_stop,
  input  logic              ir_mode,
  output logic              tx_line,
  output logic              busy
);
  localparam int SUB_W = $clog2(OVS);

  tx_fmt_t          fmt_live;
  tx_fmt_t          fmt_hold;
  logic             level;
  logic [SUB_W-1:0] sub_idx;
  logic             ir_sel;

  assign fmt_live = '{wlen: word_len, stop2: two_stop, ir: ir_mode};
  assign in_ready = !busy;

  ser_tx_bitseq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .load      (in_valid && in_ready),
    .data      (in_data),
    .fmt_in    (fmt_live),
    .busy      (busy),
    .bit_level (level),
    .sub_idx   (sub_idx),
    .fmt_q     (fmt_hold)
  );

  assign ir_sel = busy ? fmt_hold.ir : ir_mode;

  ser_tx_shaper #(.OVS(OVS), .PULSE_TICKS(PULSE_TICKS)) u_shape (
    .ir_sel  (ir_sel),
    .level   (level),
    .sub_idx (sub_idx),
    .line    (tx_line)
  );

endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic ir_mode,
  input logic tx_line,
  input logic busy
);
  assert_idle_nrz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ir_mode) |-> tx_line);

  assert_idle_ir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ir_mode) |-> !tx_line);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(!ir_mode)) |-> !tx_line);

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(ir_mode)) |-> tx_line);

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> (busy && $stable(tx_line)));
endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ir_mode  (ir_mode),
  .tx_line  (tx_line),
  .busy     (busy)
);

// File: tb/ser_frame_tx_tb_top.sv
module ser_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] word_len = '0;
  logic       two_stop = 1'b0;
  logic       ir_mode = 1'b0;
  logic       tx_line;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 1;
  int tdiv_cnt = 0;
  bit done     = 0;

  ser_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .word_len(word_len),
    .two_stop(two_stop), .ir_mode(ir_mode), .tx_line(tx_line), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    tdiv_cnt = (tdiv_cnt + 1 >= tick_div) ? 0 : tdiv_cnt + 1;
    tick16 = (tdiv_cnt == 0);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "in_ready after reset", in_ready, 1);
    check("R1", "idle line nrz", tx_line, 1);
    ir_mode = 1'b1;
    #1;
    check("R1", "idle line ir", tx_line, 0);
    ir_mode = 1'b0;
  endtask

  // Sends one frame and compares every tick position against the expected waveform.
  task automatic run_frame(input string req, input logic [7:0] d, input logic [1:0] wl,
                           input logic st2, input logic ir, input bit poke);
    int nb = 5 + wl;
    int total = (1 + nb + (st2 ? 2 : 1)) * 16;
    int n = 0;
    int bad = 0;
    int busy_bad = 0;
    int fa = 0, fe = 0, fn = 0;
    @(negedge clk);
    in_data = d; word_len = wl; two_stop = st2; ir_mode = ir; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    while (n < total) begin
      @(negedge clk);
      if (!busy) busy_bad++;
      if (tick16) begin
        int b = n / 16;
        int s = n % 16;
        logic lvl;
        logic exp;
        if (b == 0)       lvl = 1'b0;
        else if (b <= nb) lvl = d[b-1];
        else              lvl = 1'b1;
        exp = ir ? (!lvl && s < 3) : lvl;
        if (tx_line !== exp) begin
          if (bad == 0) begin fa = tx_line; fe = exp; fn = n; end
          bad++;
        end
        n++;
        if (poke && n == 20) begin
          in_valid = 1'b1; in_data = ~d; word_len = ~wl; two_stop = ~st2;
        end
        if (poke && n == 30) check("R2", "in_ready low while busy", in_ready, 0);
        if (poke && n == 40) in_valid = 1'b0;
      end
    end
    if (bad != 0) $display("  first line mismatch at tick %0d", fn);
    check(req, "line waveform", (bad == 0) ? 1 : fa, (bad == 0) ? 1 : fe);
    check("R8", "busy held through frame", busy_bad, 0);
    @(negedge clk);
    check("R8", "busy low after last stop", busy, 0);
    check("R1", "ready after frame", in_ready, 1);
  endtask

  task automatic test_back_to_back();
    // second byte offered immediately after the first completes
    run_frame("R3", 8'h3C, 2'b11, 1'b0, 1'b0, 1'b0);
    run_frame("R3", 8'hC3, 2'b11, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    run_frame("R3", 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0);
    run_frame("R4", 8'h0B, 2'b00, 1'b0, 1'b0, 1'b0);
    run_frame("R4", 8'h2D, 2'b01, 1'b1, 1'b0, 1'b0);
    run_frame("R5", 8'h55, 2'b10, 1'b1, 1'b0, 1'b0);
    run_frame("R6", 8'hE0, 2'b00, 1'b0, 1'b0, 1'b0);
    run_frame("R7", 8'h00, 2'b11, 1'b0, 1'b1, 1'b0);
    run_frame("R7", 8'h5A, 2'b11, 1'b1, 1'b1, 1'b0);
    run_frame("R9", 8'h96, 2'b11, 1'b0, 1'b0, 1'b1);
    run_frame("R9", 8'h13, 2'b00, 1'b1, 1'b1, 1'b1);
    test_back_to_back();
    tick_div = 3;
    run_frame("R10", 8'h6C, 2'b10, 1'b0, 1'b1, 1'b0);
    run_frame("R10", 8'hB1, 2'b11, 1'b1, 1'b0, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule